// File: doc/BRIEF.md
# SMBus Client Register Interface

This block is a two-wire bus client that connects an SMBus or I2C host to a small register file. The bus clock and data lines are sampled with a faster system clock, passed through two-flop synchronizers, and turned into edge and bus-condition events. A byte engine then receives the address byte, checks it against a single fixed client address, and runs either a write transfer or a read transfer.

In a write transfer, the first data byte sets an internal register pointer. Each later byte is written to the register at that pointer, and the pointer then steps forward. In a read transfer, bytes are returned from the pointer, and the pointer steps forward after each byte is fetched. A host usually sets the pointer in a write, issues a repeated Start, and then reads. The client drives the data line only through an open-drain enable. It never holds the clock line low. Every Stop returns the protocol logic to idle.

Top module: `smb_client`

## Requirements
- R1: Start is a falling edge of the data line while the clock line is high, and Stop is a rising edge of the data line while the clock line is high. Both lines are seen through two-flop synchronizers.
- R2: After a Start, the client receives eight bits, most significant first: a 7-bit address and then a direction bit (0 = host writes, 1 = host reads). If the address equals DEV_ADDR (default 7'b0101000), the client acknowledges by pulling the data line low for the ninth clock.
- R3: For any other address, the client does not drive the data line and issues no register write until the next Start or Stop.
- R4: In a write transfer, the first data byte loads the register pointer from its low AW bits, and the client acknowledges that byte.
- R5: Each later write byte produces a one-cycle `reg_wr_o` pulse. The pulse carries the byte on `reg_wdata_o` and the current pointer on `reg_addr_o`. The pointer then increments modulo 2^AW, and the byte is acknowledged.
- R6: In a read transfer, the client returns the register at the pointer, most significant bit first, and increments the pointer after each byte it fetches. It sends another byte each time the host acknowledges.
- R7: When the host does not acknowledge a read byte, the client stops driving the data line until the next Start or Stop.
- R8: A repeated Start with no Stop before it restarts address reception and keeps the pointer, so a pointer write can be followed by a read.
- R9: A Stop releases the data line and returns the client to idle. The pointer keeps its value into the next transaction.
- R10: The data-drive enable changes only while the synchronized clock line is low. The block has no output that acts on the clock line.
- R11: While `rst_n` is low, the data-drive enable and `reg_wr_o` are 0 and the pointer (`reg_addr_o`) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_drive_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| reg_wr_o | output | 1 | One-cycle write strobe to the register file |
| reg_addr_o | output | AW | Register pointer, used for both reads and writes |
| reg_wdata_o | output | 8 | Write data to the register file |
| reg_rdata_i | input | 8 | Combinational read data of the register at `reg_addr_o` |

## Verification
The assertions assume the host keeps the bus well formed. The data line changes only while the clock is low, except for Start and Stop. Each clock phase lasts several system clocks longer than the three-cycle synchronizer delay. Under those conditions a Start or Stop can never arrive while the client pulls the line low. The bench host bit-bangs every transfer with a fixed six-cycle phase and sets the data line only in the low phase. It also ends every read with a NACK before the Stop or repeated Start, so the stimulus stays within these conditions.

// File: rtl/smb_pkg.sv
// Shared types for the bus client.
// Assumes: nothing beyond the standard language.
package smb_pkg;

    // Protocol phase of the client.
    typedef enum logic [2:0] {
        PH_IDLE,     // waiting for a Start
        PH_ADDR,     // shifting in the address byte
        PH_ADDR_ACK, // acknowledging our address
        PH_WR_RX,    // shifting in a write byte
        PH_WR_ACK,   // acknowledging a write byte
        PH_RD_TX,    // shifting out a read byte
        PH_RD_ACK,   // sampling the host acknowledge
        PH_IGNORE    // not addressed / host NACKed: passive
    } phase_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/smb_line_sync.sv
// Two-flop synchronizer for one bus line, plus one more delay stage used
// to detect edges of the synchronized level.
// Assumes: the line idles high (open-drain bus with a pull-up), so all
// stages reset to 1.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] pipe;

    // Shift the raw line through the synchronizer and the edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], line_i};
        end
    end

    // Synchronized level is the last synchronizer stage; edges compare it
    // with the stage after it.
    always_comb begin
        lvl_o  = pipe[LAST];
        rise_o = pipe[LAST] & ~pipe[STAGES];
        fall_o = ~pipe[LAST] & pipe[STAGES];
    end

endmodule

// File: rtl/smb_cond_detect.sv
// Turns synchronized clock-level and data-edge information into Start and
// Stop events.
// Assumes: both inputs come from synchronizers of equal depth, so their
// relative timing is preserved.
module smb_cond_detect (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    // A data edge while the clock is high is a bus condition, not a bit.
    always_comb begin
        start_o = sda_fall & scl_lvl;
        stop_o  = sda_rise & scl_lvl;
    end

endmodule

// File: rtl/smb_client_fsm.sv
// Byte engine of the client: address match, pointer load, auto-incremented
// writes and reads, acknowledge generation and host acknowledge sampling.
// Assumes: single-cycle scl edge pulses and Start/Stop events from the
// synchronized domain; read data is combinational on the pointer.
// The data-drive enable is updated only on a synchronized clock fall or on
// a Start/Stop.
module smb_client_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0101000,
    parameter int         AW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rdata_i,
    output logic          drive_o,
    output logic          wr_o,
    output logic [AW-1:0] ptr_o,
    output logic [7:0]    wdata_o
);
    localparam int          CW       = $clog2(BYTE_BITS + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_BITS);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    phase_t        phase;
    logic [CW-1:0] bit_cnt;
    logic [7:0]    rx_sr;
    logic [7:0]    tx_sr;
    logic [AW-1:0] ptr;
    logic          host_rd;
    logic          first_byte;
    logic          host_ack;
    logic          drive;
    logic          wr_pulse;
    logic [7:0]    wdata;

    logic          byte_in;
    logic          rx_done;
    logic          addr_hit;

    // Decode shift-in activity and the address comparison.
    always_comb begin
        byte_in  = scl_rise && (bit_cnt != CNT_FULL);
        rx_done  = scl_fall && (bit_cnt == CNT_FULL);
        addr_hit = (rx_sr[7:1] == DEV_ADDR);
    end

    // Protocol sequencing; Start/Stop take priority over bit activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            ptr        <= '0;
            host_rd    <= 1'b0;
            first_byte <= 1'b0;
            host_ack   <= 1'b0;
            drive      <= 1'b0;
            wr_pulse   <= 1'b0;
            wdata      <= '0;
        end else begin
            wr_pulse <= 1'b0;
            if (wr_pulse) begin
                ptr <= ptr + 1'b1;
            end
            if (start_det) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                drive   <= 1'b0;
            end else if (stop_det) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                drive   <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR: begin
                        if (byte_in) begin
                            rx_sr   <= {rx_sr[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + CNT_ONE;
                        end else if (rx_done) begin
                            if (addr_hit) begin
                                phase   <= PH_ADDR_ACK;
                                host_rd <= rx_sr[0];
                                drive   <= 1'b1;
                            end else begin
                                phase <= PH_IGNORE;
                            end
                        end
                    end
                    PH_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (host_rd) begin
                                phase <= PH_RD_TX;
                                tx_sr <= rdata_i;
                                drive <= ~rdata_i[7];
                                ptr   <= ptr + 1'b1;
                            end else begin
                                phase      <= PH_WR_RX;
                                first_byte <= 1'b1;
                                drive      <= 1'b0;
                            end
                        end
                    end
                    PH_WR_RX: begin
                        if (byte_in) begin
                            rx_sr   <= {rx_sr[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + CNT_ONE;
                        end else if (rx_done) begin
                            phase <= PH_WR_ACK;
                            drive <= 1'b1;
                            if (first_byte) begin
                                ptr <= rx_sr[AW-1:0];
                            end else begin
                                wr_pulse <= 1'b1;
                                wdata    <= rx_sr;
                            end
                        end
                    end
                    PH_WR_ACK: begin
                        if (scl_fall) begin
                            phase      <= PH_WR_RX;
                            bit_cnt    <= '0;
                            first_byte <= 1'b0;
                            drive      <= 1'b0;
                        end
                    end
                    PH_RD_TX: begin
                        if (byte_in) begin
                            bit_cnt <= bit_cnt + CNT_ONE;
                        end else if (scl_fall) begin
                            if (bit_cnt == CNT_FULL) begin
                                phase <= PH_RD_ACK;
                                drive <= 1'b0;
                            end else begin
                                tx_sr <= {tx_sr[6:0], 1'b0};
                                drive <= ~tx_sr[6];
                            end
                        end
                    end
                    PH_RD_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                phase   <= PH_RD_TX;
                                bit_cnt <= '0;
                                tx_sr   <= rdata_i;
                                drive   <= ~rdata_i[7];
                                ptr     <= ptr + 1'b1;
                            end else begin
                                phase <= PH_IGNORE;
                            end
                        end
                    end
                    default: begin
                        // PH_IDLE and PH_IGNORE wait for a bus condition.
                    end
                endcase
            end
        end
    end

    // Drive the outputs straight from state registers.
    always_comb begin
        drive_o = drive;
        wr_o    = wr_pulse;
        ptr_o   = ptr;
        wdata_o = wdata;
    end

endmodule

// File: rtl/smb_client.sv
// Top of the bus client: line synchronizers, Start/Stop detection and the
// byte engine. The data line is driven open-drain through sda_drive_o;
// there is no clock-line output, so the client never stretches the clock.
// Assumes: clk runs several times faster than the bus clock phase length.
module smb_client #(
    parameter logic [6:0] DEV_ADDR    = 7'b0101000,
    parameter int         AW          = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_drive_o,
    output logic          reg_wr_o,
    output logic [AW-1:0] reg_addr_o,
    output logic [7:0]    reg_wdata_o,
    input  logic [7:0]    reg_rdata_i
);
    localparam int NLINES = 2;
    localparam int L_SCL  = 0;
    localparam int L_SDA  = 1;

    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_lvl;
    logic [NLINES-1:0] line_rise;
    logic [NLINES-1:0] line_fall;

    logic scl_lvl;
    logic start_det;
    logic stop_det;

    // Gather the raw pins into one vector for the synchronizer array.
    always_comb begin
        line_raw[L_SCL] = scl_i;
        line_raw[L_SDA] = sda_i;
        scl_lvl         = line_lvl[L_SCL];
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_raw[g]),
            .lvl_o  (line_lvl[g]),
            .rise_o (line_rise[g]),
            .fall_o (line_fall[g])
        );
    end

    smb_cond_detect u_cond (
        .scl_lvl  (scl_lvl),
        .sda_rise (line_rise[L_SDA]),
        .sda_fall (line_fall[L_SDA]),
        .start_o  (start_det),
        .stop_o   (stop_det)
    );

    smb_client_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (line_rise[L_SCL]),
        .scl_fall  (line_fall[L_SCL]),
        .sda_lvl   (line_lvl[L_SDA]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata_i   (reg_rdata_i),
        .drive_o   (sda_drive_o),
        .wr_o      (reg_wr_o),
        .ptr_o     (reg_addr_o),
        .wdata_o   (reg_wdata_o)
    );

endmodule

// File: rtl/smb_client_chk.sv
// Protocol checker for smb_client, bound into every instance.
// Assumes: the host changes the data line only while the clock is low,
// except for Start and Stop, and holds each clock phase longer than the
// synchronizer delay.
module smb_client_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          start_det,
    input logic          stop_det,
    input logic          drive,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr
);
    AST_DRV_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (drive != $past(drive)) |-> !scl_lvl); // R10
    AST_WR_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> !scl_lvl); // R10
    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R5
    AST_PTR_STEP_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> (reg_addr == AW'($past(reg_addr) + 1'b1))); // R5
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !drive); // R9
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> !drive); // R8
    AST_PTR_HOLD_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n) (stop_det && !reg_wr) |=> $stable(reg_addr)); // R9
endmodule

bind smb_client smb_client_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .drive     (sda_drive_o),
    .reg_wr    (reg_wr_o),
    .reg_addr  (reg_addr_o)
);

// File: tb/tb_smb_client.sv
// Bench: bit-banged bus host, bench-side register file, expected-value
// model of pointer and register contents, directed and random transfers.
module tb_smb_client;
    localparam int          AW    = 4;
    localparam int          NREG  = 1 << AW;
    localparam logic [6:0]  MY    = 7'b0101000;
    localparam int          H     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_h = 1'b1;
    logic          sda_h = 1'b1;
    logic          sda_bus;
    logic          sda_drive_o;
    logic          reg_wr_o;
    logic [AW-1:0] reg_addr_o;
    logic [7:0]    reg_wdata_o;
    logic [7:0]    reg_rdata_i;

    logic [7:0]    mem [NREG];
    logic [7:0]    exp_mem [NREG];
    logic [AW-1:0] exp_ptr = '0;

    int n_chk = 0;
    int n_bad = 0;
    int drv_cycles = 0;
    int drv_hi_viol = 0;
    logic prev_drv = 1'b0;
    logic smp;

    always #5 clk = ~clk;

    assign sda_bus     = sda_h & ~sda_drive_o;
    assign reg_rdata_i = mem[reg_addr_o];

    smb_client #(.DEV_ADDR(MY), .AW(AW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_h),
        .sda_i       (sda_bus),
        .sda_drive_o (sda_drive_o),
        .reg_wr_o    (reg_wr_o),
        .reg_addr_o  (reg_addr_o),
        .reg_wdata_o (reg_wdata_o),
        .reg_rdata_i (reg_rdata_i)
    );

    // Bench register file written by the client's strobe.
    always @(posedge clk) begin
        if (reg_wr_o) mem[reg_addr_o] <= reg_wdata_o;
    end

    // Monitor drive activity and drive changes while the host clock is high.
    always @(negedge clk) begin
        if (sda_drive_o) drv_cycles++;
        if (rst_n && (sda_drive_o !== prev_drv) && scl_h) drv_hi_viol++;
        prev_drv = sda_drive_o;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_bit(input logic b);
        sda_h = b;
        tick(H);
        scl_h = 1'b1;
        tick(H);
        smp = sda_bus;
        scl_h = 1'b0;
        tick(H);
    endtask

    task automatic bus_start();
        sda_h = 1'b1;
        tick(H);
        scl_h = 1'b1;
        tick(H);
        sda_h = 1'b0;
        tick(H);
        scl_h = 1'b0;
        tick(H);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0;
        tick(H);
        scl_h = 1'b1;
        tick(H);
        sda_h = 1'b1;
        tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_bit(1'b1);
        ack = ~smp;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1);
            b[i] = smp;
        end
        bus_bit(~host_ack);
    endtask

    task automatic mem_compare(input string req);
        int diffs = 0;
        for (int i = 0; i < NREG; i++) if (mem[i] !== exp_mem[i]) diffs++;
        check(req, diffs, 0);
    endtask

    // Write transfer: pointer byte then n data bytes.
    task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n);
        logic ack;
        logic hit = (a == MY);
        int   d0 = drv_cycles;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check(hit ? "R2 addr ack" : "R3 foreign addr no ack", ack, hit);
        send_byte(p, ack);
        check(hit ? "R4 ptr ack" : "R3 ptr no ack", ack, hit);
        if (hit) exp_ptr = p[AW-1:0];
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = 8'($urandom);
            send_byte(d, ack);
            check(hit ? "R5 data ack" : "R3 data no ack", ack, hit);
            if (hit) begin
                exp_mem[exp_ptr] = d;
                exp_ptr = exp_ptr + 1'b1;
            end
        end
        bus_stop();
        tick(4);
        if (!hit) check("R3 never drove", drv_cycles - d0, 0);
        mem_compare(hit ? "R5 register contents" : "R3 registers untouched");
        check("R9 pointer kept after stop", reg_addr_o, exp_ptr);
    endtask

    // Read transfer of n bytes; optional pointer write and repeated Start.
    task automatic rd_txn(input logic [6:0] a, input int n, input logic set_ptr,
                          input logic [7:0] p);
        logic ack;
        logic [7:0] b;
        logic hit = (a == MY);
        int   d0;
        bus_start();
        if (set_ptr) begin
            send_byte({MY, 1'b0}, ack);
            check("R2 addr ack before rstart", ack, 1);
            send_byte(p, ack);
            check("R4 ptr ack before rstart", ack, 1);
            exp_ptr = p[AW-1:0];
            bus_start();
        end
        d0 = drv_cycles;
        send_byte({a, 1'b1}, ack);
        check(hit ? "R8 read addr ack" : "R3 foreign read no ack", ack, hit);
        if (hit) begin
            for (int k = 0; k < n; k++) begin
                recv_byte(k != n - 1, b);
                check("R6 read data", b, exp_mem[exp_ptr]);
                exp_ptr = exp_ptr + 1'b1;
            end
            d0 = drv_cycles;
            for (int k = 0; k < 9; k++) bus_bit(1'b1);
            check("R7 silent after nack", drv_cycles - d0, 0);
        end else begin
            for (int k = 0; k < 9; k++) bus_bit(1'b1);
            check("R3 foreign read silent", drv_cycles - d0, 0);
        end
        bus_stop();
        tick(4);
        check("R9 pointer after read", reg_addr_o, exp_ptr);
    endtask

    initial begin
        void'($urandom(32'd7341));
        for (int i = 0; i < NREG; i++) begin
            mem[i] = 8'($urandom);
            exp_mem[i] = mem[i];
        end
        tick(6);
        check("R11 drive low in reset", sda_drive_o, 0);
        check("R11 no write in reset", reg_wr_o, 0);
        check("R11 pointer zero in reset", reg_addr_o, 0);
        rst_n = 1'b1;
        tick(6);
        check("R1 idle bus no drive", sda_drive_o, 0);

        wr_txn(MY, 8'h03, 2);
        wr_txn(MY, 8'hFF, 3);            // R5 pointer wraps past the top
        rd_txn(MY, 2, 1'b1, 8'h0F);      // R8 pointer write, rstart, read
        rd_txn(MY, 3, 1'b0, 8'h00);      // R9 continues from kept pointer
        wr_txn(7'b0101001, 8'h02, 2);    // R3 neighbour address
        rd_txn(7'b1010000, 1, 1'b0, 8'h00);
        rd_txn(MY, 1, 1'b1, 8'h05);      // R7 single byte then NACK

        for (int t = 0; t < 30; t++) begin
            int kind = int'($urandom_range(0, 9));
            logic [6:0] a = (kind == 0) ? 7'($urandom) : MY;
            if (kind < 5) wr_txn(a, 8'($urandom), int'($urandom_range(0, 4)));
            else rd_txn(a, int'($urandom_range(1, 5)), kind[0], 8'($urandom));
        end

        check("R10 drive changed while clock high", drv_hi_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule